// File: doc/BRIEF.md
# Frame-Synchronised LSB-First Serial Transmitter

This block sends one data word per frame on a single serial line, least-significant bit first. A host writes a word into a holding register through a simple strobe-and-data port. When the frame-sync input rises, the block arms itself. On the next bit-clock enable it copies the holding register into a shift register and drives bit 0 on the serial output at that same clock edge, so there is no idle bit between the load and the first bit. Each later bit-clock enable presents the next bit until the selected word length has been sent.

Because the word is buffered twice, the host can write the next word while the current one is still leaving the shift register. A size-select input picks 8-bit or 16-bit words. In 8-bit mode the data sits in the low byte and the upper byte is ignored. The block has two error indications, frame error and collision, and in this mode both are held inactive. Bit-clock generation, channel time slotting and receive logic live elsewhere.

Top module: `lsb_serial_tx`

## Requirements
- R1: Synchronous active-high reset drives `sdo` and `done` low and clears the holding register. A frame sent after reset with no host write carries all zero bits.
- R2: A rising edge of `fsync` is taken when it is sampled at a clock edge where the previous sample was low. At the first later edge where `bclk_en` is high, the holding register is loaded into the shift register, and bit 0 appears on `sdo` right after that same edge.
- R3: Bits leave least-significant first. Each later edge with `bclk_en` high presents the next bit. At an edge where `bclk_en` is low, `sdo` does not change.
- R4: With `size8` low (0), a word is 16 bits long.
- R5: With `size8` high (1), a word is 8 bits long and bits 15..8 of the holding register never reach `sdo`. `size8` is sampled at the load edge.
- R6: After the last bit of a word, the next `bclk_en` edge raises `done`. `sdo` keeps the last bit driven until the next load, and that load clears `done`.
- R7: A host write made while a word is shifting does not alter the bits still to be sent. The following frame sends the newly written word.
- R8: A frame-sync rise while a word is mid-shift restarts transmission from bit 0 of the current holding-register contents at the next `bclk_en` edge.
- R9: `frame_err` and `collision` stay low at all times.
- R10: While `fsync` stays high, only one load occurs. A new load needs `fsync` to fall and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 16 | Host write data (8-bit words right-justified) |
| size8 | input | 1 | 1 selects 8-bit words, 0 selects 16-bit words |
| bclk_en | input | 1 | One-cycle enable marking a bit-clock rising edge |
| fsync | input | 1 | Frame sync, acted on at its rising edge |
| sdo | output | 1 | Serial data output, registered |
| done | output | 1 | Word complete, held until the next load |
| frame_err | output | 1 | Frame error indication, forced low |
| collision | output | 1 | Collision indication, forced low |

## Verification
A wrong bit count or a stale shift register shows up on `sdo` at the very next `bclk_en` edge. It also shows on `done`, which rises one bit clock early or late against the word length. If the holding register is corrupted, or a mid-shift write leaks into the live word, the fault appears in the first bit that follows the write, or in bit 0 of the next frame. An armed-sync flag that is cleared wrongly, or not cleared at all, shows up as a missing load or an extra load, one bit clock after the frame sync.

// File: rtl/tx_pkg.sv
package tx_pkg;

  typedef enum logic {
    SZ_WORD = 1'b0,
    SZ_BYTE = 1'b1
  } tx_size_e;

  // Number of bits shifted for a given size selection
  function automatic int unsigned word_bits(input tx_size_e sz,
                                            input int unsigned full_w,
                                            input int unsigned short_w);
    return (sz == SZ_BYTE) ? short_w : full_w;
  endfunction

endpackage

// File: rtl/tx_sync_detect.sv
module tx_sync_detect (
  input  logic clk,
  input  logic rst,
  input  logic fsync,
  input  logic consume,
  output logic armed
);

  logic fsync_d;
  logic rise;

  assign rise = fsync & ~fsync_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsync_d <= 1'b0;
      armed   <= 1'b0;
    end else begin
      fsync_d <= fsync;
      armed   <= rise | (armed & ~consume);
    end
  end

  // a consumed arm with no fresh edge must drop
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (armed && consume && !rise) |=> !armed); // R10

  // a detected edge always arms
  AST_RISE_ARMS: assert property (@(posedge clk) disable iff (rst)
    rise |=> armed); // R2

endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] hold_q
);

  always_ff @(posedge clk) begin
    if (rst)        hold_q <= '0;
    else if (wr_en) hold_q <= wr_data;
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(hold_q)); // R7

endmodule

// File: rtl/tx_shift_engine.sv
module tx_shift_engine
  import tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_en,
  input  logic              start,
  input  logic [DATA_W-1:0] hold_word,
  input  tx_size_e          size_sel,
  output logic              load,
  output logic              sdo,
  output logic              done
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [DATA_W-1:0] LOW_MASK =
    {{(DATA_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] masked;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  len_q;
  logic              active;

  assign load   = bclk_en & start;
  assign masked = (size_sel == SZ_BYTE) ? (hold_word & LOW_MASK) : hold_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      cnt    <= '0;
      len_q  <= '0;
      active <= 1'b0;
      done   <= 1'b0;
      sdo    <= 1'b0;
    end else if (load) begin
      shreg  <= masked >> 1;
      sdo    <= masked[0];
      cnt    <= CNT_W'(1);
      len_q  <= CNT_W'(word_bits(size_sel, DATA_W, SHORT_W));
      active <= 1'b1;
      done   <= 1'b0;
    end else if (bclk_en && active) begin
      if (cnt == len_q) begin
        active <= 1'b0;
        done   <= 1'b1;
      end else begin
        sdo   <= shreg[0];
        shreg <= shreg >> 1;
        cnt   <= cnt + CNT_W'(1);
      end
    end
  end

  AST_LOAD_BIT0: assert property (@(posedge clk) disable iff (rst)
    load |=> (sdo == $past(hold_word[0]))); // R2

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bclk_en |=> $stable(sdo)); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= CNT_W'(DATA_W))); // R4

  AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (active && len_q == CNT_W'(SHORT_W)) |-> (cnt <= CNT_W'(SHORT_W))); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !active); // R6

  AST_DONE_SDO: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> $stable(sdo)); // R6

endmodule

// File: rtl/lsb_serial_tx.sv
module lsb_serial_tx
  import tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              size8,
  input  logic              bclk_en,
  input  logic              fsync,
  output logic              sdo,
  output logic              done,
  output logic              frame_err,
  output logic              collision
);

  logic [DATA_W-1:0] hold_q;
  logic              armed;
  logic              load;
  tx_size_e          size_sel;

  assign size_sel = size8 ? SZ_BYTE : SZ_WORD;

  // error indications are not generated in this transmit mode (R9)
  assign frame_err = 1'b0;
  assign collision = 1'b0;

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .hold_q  (hold_q)
  );

  tx_sync_detect u_sync (
    .clk     (clk),
    .rst     (rst),
    .fsync   (fsync),
    .consume (load),
    .armed   (armed)
  );

  tx_shift_engine #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .bclk_en   (bclk_en),
    .start     (armed),
    .hold_word (hold_q),
    .size_sel  (size_sel),
    .load      (load),
    .sdo       (sdo),
    .done      (done)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (!sdo && !done)); // R1

endmodule

// File: tb/sim_lsb_serial_tx.sv
module sim_lsb_serial_tx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        size8 = 1'b0;
  logic        bclk_en = 1'b0;
  logic        fsync = 1'b0;
  logic        sdo, done, frame_err, collision;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lsb_serial_tx u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .size8(size8),
    .bclk_en(bclk_en), .fsync(fsync), .sdo(sdo), .done(done),
    .frame_err(frame_err), .collision(collision)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive inputs at a falling edge, let one rising edge pass, sample at next falling edge
  task automatic step(input bit be, input bit fs);
    bclk_en = be;
    fsync   = fs;
    @(negedge clk);
    bclk_en = 1'b0;
  endtask

  task automatic host_write(input logic [15:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // arm with a fresh frame sync, then shift n bits, checking each one
  task automatic send_check(input logic [15:0] d, input int n, input string req,
                            input bit fs_level);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    for (int i = 0; i < n; i++) begin
      step(1'b1, fs_level);
      chk(sdo == d[i], req, sdo, d[i]);
      chk(done == 1'b0, {req, " busy"}, done, 0);
      step(1'b0, fs_level);
      chk(sdo == d[i], "R3 stable", sdo, d[i]);
    end
    step(1'b1, fs_level);
    chk(done == 1'b1, "R6 done", done, 1);
    chk(sdo == d[n-1], "R6 hold", sdo, d[n-1]);
  endtask

  task automatic t_reset();
    chk(sdo == 1'b0, "R1 sdo", sdo, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(frame_err == 1'b0 && collision == 1'b0, "R9", {frame_err, collision}, 0);
    size8 = 1'b0;
    send_check(16'h0000, 16, "R1 zero", 1'b0);
  endtask

  task automatic t_word16(input logic [15:0] d);
    size8 = 1'b0;
    host_write(d);
    send_check(d, 16, "R4", 1'b0);
    step(1'b1, 1'b0);
    chk(done == 1'b1 && sdo == d[15], "R6 idle", {done, sdo}, {1'b1, d[15]});
  endtask

  task automatic t_word8();
    size8 = 1'b1;
    host_write(16'hFF5A);
    send_check(16'h005A, 8, "R5", 1'b0);
    size8 = 1'b0;
  endtask

  task automatic t_write_during();
    logic [15:0] a = 16'h1234;
    logic [15:0] b = 16'hBEEF;
    size8 = 1'b0;
    host_write(a);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0);
      chk(sdo == a[i], "R7 old word", sdo, a[i]);
      if (i == 4) host_write(b);
    end
    send_check(b, 16, "R7 new word", 1'b0);
  endtask

  task automatic t_restart();
    logic [15:0] a = 16'h00FF;
    logic [15:0] b = 16'hF0F0;
    size8 = 1'b0;
    host_write(a);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0);
      chk(sdo == a[i], "R8 first", sdo, a[i]);
    end
    host_write(b);
    send_check(b, 16, "R8 restart", 1'b0);
  endtask

  task automatic t_level();
    logic [15:0] a = 16'h6C39;
    size8 = 1'b0;
    host_write(a);
    send_check(a, 16, "R10 word", 1'b1);
    host_write(16'h0001);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b1);
      chk(done == 1'b1 && sdo == a[15], "R10 no reload", {done, sdo}, {1'b1, a[15]});
    end
    step(1'b0, 1'b0);
    chk(frame_err == 1'b0 && collision == 1'b0, "R9", {frame_err, collision}, 0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_word16(16'hA5C3);
    t_word16(16'h8001);
    t_word8();
    t_write_during();
    t_restart();
    t_level();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule